// File: doc/BRIEF.md
# Write-Through Data Cache with Posted Store Buffer

This block sits between a processor's load/store port and a single memory port. It keeps 2 KiB of recently loaded data in a direct-mapped array of 64 lines. Each line is 32 bytes, or eight 32-bit words, and every word has its own valid flag. A load that finds its word present is answered from the array with no memory traffic. A load that misses fetches only the word that was asked for. That word is placed in the array and marked valid. The other words of the line stay as they were, unless the line held a different tag, in which case they are dropped.

Every store is written through to memory. A store that finds its word present also updates that word in the array, byte by byte. A store that misses leaves the array alone. Stores are posted into a two-entry buffer, so the processor moves on at once and the buffer drains to memory in the background. A load that has to use memory waits until the buffer is empty, so it never reads a location that still has a store in flight.

A disable input sends every load to memory and stops refills while it is high. Anything already cached survives and is served again once the input falls. Stores update words that are present whether the input is high or low, which keeps the array consistent with memory.

Top module: `wt_dcache`

## Requirements
- R1: After reset every valid flag is clear, `cpu_rvalid` and `mem_req` are low, `cpu_stall` is low while no request is presented, and the first load of any address goes to memory.
- R2: The address is split as byte offset [1:0], word within line [4:2], line index [10:5] and tag [31:11]. A refill whose tag differs from the stored tag of its line leaves only the refilled word valid in that line.
- R3: A load that hits (present word, disable low) is accepted in the cycle it is presented, with no stall and no memory access. `cpu_rvalid` is high with the cached word in the next cycle.
- R4: A load miss stalls the port and issues one memory read at the word-aligned address with `mem_be` = 4'b1111. The load is accepted in the `mem_ack` cycle and returns the memory word one cycle later. Only that word becomes valid, so its neighbours still miss.
- R5: Stores are written to memory in the order they were accepted, with their byte enables. A store that misses does not allocate: a later load of that word still goes to memory and returns the stored value.
- R6: A store to a present word updates the cached copy only in the bytes whose enable bit i is set, where bit i covers data bits [8i+7:8i].
- R7: With two stores buffered, a further store is stalled until the buffer has space at the start of a cycle. A store into a buffer with room is accepted without stall.
- R8: A load that needs memory issues its read only after every buffered store has been acknowledged.
- R9: While `cache_off` is high, every load reads memory and no refill writes the array. A word cached before the input rose is served unchanged, with no memory access, after the input falls.
- R10: Once `mem_req` is raised, it and `mem_we`, `mem_addr` and `mem_be` hold steady until the cycle in which `mem_ack` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cache_off | input | 1 | High: loads bypass the array and refills are suppressed |
| cpu_req | input | 1 | Processor request, held with its fields while stalled |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address |
| cpu_be | input | 4 | Store byte enables |
| cpu_wdata | input | 32 | Store data |
| cpu_stall | output | 1 | Request is not accepted this cycle |
| cpu_rvalid | output | 1 | Load data valid, one cycle after acceptance |
| cpu_rdata | output | 32 | Load data |
| mem_req | output | 1 | Memory transfer requested |
| mem_we | output | 1 | 1 = buffered store write, 0 = word read |
| mem_addr | output | 32 | Memory address |
| mem_be | output | 4 | Memory byte enables |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Transfer completes in this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |

## Verification
The bound checker keeps its own count of stores that have been accepted but not yet acknowledged. It uses that count on every cycle to check that the buffer never exceeds two entries, that a store is stalled when the count is full, and that no memory read appears while the count is non-zero. The checker also enforces the load-response timing, the stability of the memory request while it waits, and the memory bypass of loads accepted while the cache is disabled. The actual contents of the array can only be seen through the bench's scenarios. These are: byte-masked merging on a store hit, non-allocation on a store miss, single-word refill, eviction on a tag change, and survival of cached data across a disabled period.

// File: rtl/wtdc_pkg.sv
package wtdc_pkg;
  typedef enum logic [0:0] {
    CS_IDLE = 1'b0,
    CS_MISS = 1'b1
  } ctl_state_e;
endpackage

// File: rtl/wtdc_arrays.sv
module wtdc_arrays #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LINES  = 64,
  parameter int WORDS  = 8
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic [ADDR_W-$clog2(DATA_W/8)-1:0]   lk_waddr,
  output logic                                 lk_hit,
  output logic [DATA_W-1:0]                    lk_data,
  input  logic                                 upd_en,
  input  logic [DATA_W/8-1:0]                  upd_be,
  input  logic [DATA_W-1:0]                    upd_data,
  input  logic                                 fill_en,
  input  logic [ADDR_W-$clog2(DATA_W/8)-1:0]   fill_waddr,
  input  logic [DATA_W-1:0]                    fill_data
);
  localparam int BE_W      = DATA_W / 8;
  localparam int WADDR_W   = ADDR_W - $clog2(BE_W);
  localparam int WORD_BITS = $clog2(WORDS);
  localparam int LINE_BITS = $clog2(LINES);
  localparam int IDX_W     = WORD_BITS + LINE_BITS;
  localparam int TAG_W     = WADDR_W - IDX_W;

  logic [TAG_W-1:0]              tag_q  [LINES];
  logic [DATA_W-1:0]             data_q [LINES*WORDS];
  logic [LINES-1:0][WORDS-1:0]   vld_q, vld_d;

  logic [LINE_BITS-1:0] lk_line, fl_line;
  logic [WORD_BITS-1:0] lk_word, fl_word;
  logic [TAG_W-1:0]     lk_tag, fl_tag;
  logic [DATA_W-1:0]    merged, wr_data;
  logic [IDX_W-1:0]     wr_idx;
  logic                 data_we;

  assign lk_word = lk_waddr[WORD_BITS-1:0];
  assign lk_line = lk_waddr[WORD_BITS +: LINE_BITS];
  assign lk_tag  = lk_waddr[WADDR_W-1 -: TAG_W];
  assign fl_word = fill_waddr[WORD_BITS-1:0];
  assign fl_line = fill_waddr[WORD_BITS +: LINE_BITS];
  assign fl_tag  = fill_waddr[WADDR_W-1 -: TAG_W];

  assign lk_hit  = vld_q[lk_line][lk_word] && (tag_q[lk_line] == lk_tag);
  assign lk_data = data_q[lk_waddr[IDX_W-1:0]];

  // byte lanes of a store hit
  for (genvar b = 0; b < BE_W; b++) begin : g_lane
    assign merged[b*8 +: 8] = upd_be[b] ? upd_data[b*8 +: 8] : lk_data[b*8 +: 8];
  end

  assign data_we = fill_en | (upd_en & lk_hit);
  assign wr_idx  = fill_en ? fill_waddr[IDX_W-1:0] : lk_waddr[IDX_W-1:0];
  assign wr_data = fill_en ? fill_data : merged;

  always_comb begin
    vld_d = vld_q;
    if (fill_en) begin
      vld_d[fl_line] = ((tag_q[fl_line] == fl_tag) ? vld_q[fl_line] : {WORDS{1'b0}})
                       | (WORDS'(1) << fl_word);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else if (fill_en) begin
      vld_q <= vld_d;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      tag_q[fl_line] <= fl_tag;
    end
  end

  always_ff @(posedge clk) begin
    if (data_we) begin
      data_q[wr_idx] <= wr_data;
    end
  end
endmodule

// File: rtl/wtdc_wbuf.sv
module wtdc_wbuf #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  push,
  input  logic [ADDR_W-1:0]     push_addr,
  input  logic [DATA_W/8-1:0]   push_be,
  input  logic [DATA_W-1:0]     push_data,
  input  logic                  pop,
  output logic [ADDR_W-1:0]     head_addr,
  output logic [DATA_W/8-1:0]   head_be,
  output logic [DATA_W-1:0]     head_data,
  output logic                  full,
  output logic                  empty
);
  localparam int BE_W  = DATA_W / 8;
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [BE_W-1:0]   be_q   [DEPTH];
  logic [DATA_W-1:0] data_q [DEPTH];

  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wr_ptr_d = push ? bump(wr_ptr_q) : wr_ptr_q;
    rd_ptr_d = pop  ? bump(rd_ptr_q) : rd_ptr_q;
    cnt_d    = cnt_q + CNT_W'(push) - CNT_W'(pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      addr_q[wr_ptr_q] <= push_addr;
      be_q[wr_ptr_q]   <= push_be;
      data_q[wr_ptr_q] <= push_data;
    end
  end

  assign head_addr = addr_q[rd_ptr_q];
  assign head_be   = be_q[rd_ptr_q];
  assign head_data = data_q[rd_ptr_q];
  assign full      = (cnt_q == CNT_W'(DEPTH));
  assign empty     = (cnt_q == '0);
endmodule

// File: rtl/wtdc_ctrl.sv
module wtdc_ctrl
  import wtdc_pkg::*;
#(
  parameter int WADDR_W = 30,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cpu_req,
  input  logic               cpu_we,
  input  logic [WADDR_W-1:0] cpu_waddr,
  input  logic               cache_off,
  input  logic               lk_hit,
  input  logic [DATA_W-1:0]  lk_data,
  input  logic               wb_full,
  input  logic               wb_empty,
  input  logic               mem_ack,
  input  logic [DATA_W-1:0]  mem_rdata,
  output logic               cpu_stall,
  output logic               cpu_rvalid,
  output logic [DATA_W-1:0]  cpu_rdata,
  output logic               store_go,
  output logic               rd_issue,
  output logic               fill_en,
  output logic [WADDR_W-1:0] miss_waddr
);
  ctl_state_e st_q, st_d;

  logic               idle, load_go, hit_load, miss_go, rd_done;
  logic               rsp_vld_d, rsp_vld_q;
  logic [DATA_W-1:0]  rsp_d, rsp_q;
  logic [WADDR_W-1:0] miss_q;

  assign idle     = (st_q == CS_IDLE);
  assign load_go  = idle & cpu_req & ~cpu_we;
  assign hit_load = load_go & lk_hit & ~cache_off;
  assign miss_go  = load_go & ~hit_load;
  assign store_go = idle & cpu_req & cpu_we & ~wb_full;
  // a read waits in MISS until the store buffer has drained
  assign rd_issue = (st_q == CS_MISS) & wb_empty;
  assign rd_done  = rd_issue & mem_ack;
  assign fill_en  = rd_done & ~cache_off;

  assign cpu_stall = cpu_req & ~(hit_load | store_go | rd_done);

  always_comb begin
    st_d = st_q;
    case (st_q)
      CS_IDLE: if (miss_go) st_d = CS_MISS;
      CS_MISS: if (rd_done) st_d = CS_IDLE;
      default: st_d = CS_IDLE;
    endcase
    rsp_vld_d = hit_load | rd_done;
    rsp_d     = rd_done ? mem_rdata : lk_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= CS_IDLE;
      rsp_vld_q <= 1'b0;
    end else begin
      st_q      <= st_d;
      rsp_vld_q <= rsp_vld_d;
    end
  end

  always_ff @(posedge clk) begin
    if (miss_go) begin
      miss_q <= cpu_waddr;
    end
    if (rsp_vld_d) begin
      rsp_q <= rsp_d;
    end
  end

  assign cpu_rvalid = rsp_vld_q;
  assign cpu_rdata  = rsp_q;
  assign miss_waddr = miss_q;
endmodule

// File: rtl/wt_dcache.sv
module wt_dcache #(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int CACHE_BYTES = 2048,
  parameter int LINE_BYTES  = 32,
  parameter int WB_DEPTH    = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cache_off,
  input  logic                  cpu_req,
  input  logic                  cpu_we,
  input  logic [ADDR_W-1:0]     cpu_addr,
  input  logic [DATA_W/8-1:0]   cpu_be,
  input  logic [DATA_W-1:0]     cpu_wdata,
  output logic                  cpu_stall,
  output logic                  cpu_rvalid,
  output logic [DATA_W-1:0]     cpu_rdata,
  output logic                  mem_req,
  output logic                  mem_we,
  output logic [ADDR_W-1:0]     mem_addr,
  output logic [DATA_W/8-1:0]   mem_be,
  output logic [DATA_W-1:0]     mem_wdata,
  input  logic                  mem_ack,
  input  logic [DATA_W-1:0]     mem_rdata
);
  localparam int BE_W     = DATA_W / 8;
  localparam int OFF_BITS = $clog2(BE_W);
  localparam int WADDR_W  = ADDR_W - OFF_BITS;
  localparam int WORDS    = LINE_BYTES / BE_W;
  localparam int LINES    = CACHE_BYTES / LINE_BYTES;

  logic               lk_hit, store_go, rd_issue, fill_en;
  logic               wb_full, wb_empty, wb_pop;
  logic [DATA_W-1:0]  lk_data, head_data;
  logic [ADDR_W-1:0]  head_addr;
  logic [BE_W-1:0]    head_be;
  logic [WADDR_W-1:0] miss_waddr;

  wtdc_arrays #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES), .WORDS(WORDS)
  ) u_arrays (
    .clk        (clk),
    .rst_n      (rst_n),
    .lk_waddr   (cpu_addr[ADDR_W-1:OFF_BITS]),
    .lk_hit     (lk_hit),
    .lk_data    (lk_data),
    .upd_en     (store_go),
    .upd_be     (cpu_be),
    .upd_data   (cpu_wdata),
    .fill_en    (fill_en),
    .fill_waddr (miss_waddr),
    .fill_data  (mem_rdata)
  );

  wtdc_wbuf #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(WB_DEPTH)
  ) u_wbuf (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (store_go),
    .push_addr (cpu_addr),
    .push_be   (cpu_be),
    .push_data (cpu_wdata),
    .pop       (wb_pop),
    .head_addr (head_addr),
    .head_be   (head_be),
    .head_data (head_data),
    .full      (wb_full),
    .empty     (wb_empty)
  );

  wtdc_ctrl #(
    .WADDR_W(WADDR_W), .DATA_W(DATA_W)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_req    (cpu_req),
    .cpu_we     (cpu_we),
    .cpu_waddr  (cpu_addr[ADDR_W-1:OFF_BITS]),
    .cache_off  (cache_off),
    .lk_hit     (lk_hit),
    .lk_data    (lk_data),
    .wb_full    (wb_full),
    .wb_empty   (wb_empty),
    .mem_ack    (mem_ack),
    .mem_rdata  (mem_rdata),
    .cpu_stall  (cpu_stall),
    .cpu_rvalid (cpu_rvalid),
    .cpu_rdata  (cpu_rdata),
    .store_go   (store_go),
    .rd_issue   (rd_issue),
    .fill_en    (fill_en),
    .miss_waddr (miss_waddr)
  );

  // memory port: buffered stores take priority over the waiting read
  assign wb_pop    = ~wb_empty & mem_ack;
  assign mem_req   = ~wb_empty | rd_issue;
  assign mem_we    = ~wb_empty;
  assign mem_addr  = wb_empty ? {miss_waddr, {OFF_BITS{1'b0}}} : head_addr;
  assign mem_be    = wb_empty ? {BE_W{1'b1}} : head_be;
  assign mem_wdata = head_data;
endmodule

// File: rtl/wtdc_chk.sv
module wtdc_chk #(
  parameter int ADDR_W   = 32,
  parameter int WB_DEPTH = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cache_off,
  input logic              cpu_req,
  input logic              cpu_we,
  input logic              cpu_stall,
  input logic              cpu_rvalid,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_addr
);
  localparam int CNT_W = $clog2(WB_DEPTH + 2) + 1;

  logic             st_acc, ld_acc, wr_done;
  logic [CNT_W-1:0] pend_q, pend_d;

  assign st_acc  = cpu_req & cpu_we & ~cpu_stall;
  assign ld_acc  = cpu_req & ~cpu_we & ~cpu_stall;
  assign wr_done = mem_req & mem_we & mem_ack;

  always_comb pend_d = pend_q + CNT_W'(st_acc) - CNT_W'(wr_done);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  AST_WB_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q <= CNT_W'(WB_DEPTH)); // R7

  AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && cpu_we && pend_q == CNT_W'(WB_DEPTH)) |-> cpu_stall); // R7

  AST_READ_AFTER_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |-> (pend_q == '0)); // R8

  AST_RSP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    ld_acc |=> cpu_rvalid); // R3

  AST_NO_STRAY_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_acc |=> !cpu_rvalid); // R3

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R10

  AST_OFF_LOAD_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_acc && cache_off) |-> (mem_req && !mem_we && mem_ack)); // R9
endmodule

bind wt_dcache wtdc_chk #(
  .ADDR_W(ADDR_W), .WB_DEPTH(WB_DEPTH)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cache_off  (cache_off),
  .cpu_req    (cpu_req),
  .cpu_we     (cpu_we),
  .cpu_stall  (cpu_stall),
  .cpu_rvalid (cpu_rvalid),
  .mem_req    (mem_req),
  .mem_we     (mem_we),
  .mem_ack    (mem_ack),
  .mem_addr   (mem_addr)
);

// File: tb/wt_dcache_test.sv
module wt_dcache_test;
  logic        clk, rst_n, cache_off;
  logic        cpu_req, cpu_we;
  logic [31:0] cpu_addr, cpu_wdata;
  logic [3:0]  cpu_be;
  logic        cpu_stall, cpu_rvalid;
  logic [31:0] cpu_rdata;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0]  mem_be;

  wt_dcache uut (
    .clk(clk), .rst_n(rst_n), .cache_off(cache_off),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_be(cpu_be),
    .cpu_wdata(cpu_wdata), .cpu_stall(cpu_stall), .cpu_rvalid(cpu_rvalid),
    .cpu_rdata(cpu_rdata), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int checks = 0, failures = 0;
  int lat = 1, wcnt = 0, reads = 0, pend = 0;
  int drain_viol = 0, hold_viol = 0, rd_be_bad = 0;
  logic        hold_wait = 1'b0, hold_we = 1'b0;
  logic [31:0] hold_addr = '0;
  logic [31:0] mem [logic [31:0]];
  logic [31:0] wlog [$];

  function automatic logic [31:0] mval(input logic [31:0] a);
    logic [31:0] w;
    w = {a[31:2], 2'b00};
    return mem.exists(w) ? mem[w] : (w ^ 32'h5A5A_0000);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // memory model: acknowledges after lat idle negedges, data with ack
  always @(negedge clk) begin
    if (mem_ack) begin
      mem_ack <= 1'b0;
      wcnt = 0;
    end else if (mem_req) begin
      if (wcnt >= lat) begin
        mem_ack   <= 1'b1;
        mem_rdata <= mval(mem_addr);
      end else begin
        wcnt++;
      end
    end
  end

  // monitor: completes transfers and watches ordering and hold (R4, R5, R8, R10)
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      if (hold_wait && (!mem_req || mem_addr !== hold_addr || mem_we !== hold_we))
        hold_viol++;
      hold_wait = mem_req && !mem_ack;
      hold_addr = mem_addr;
      hold_we   = mem_we;
      if (mem_req && mem_ack) begin
        if (mem_we) begin
          logic [31:0] v;
          v = mval(mem_addr);
          for (int b = 0; b < 4; b++) if (mem_be[b]) v[b*8 +: 8] = mem_wdata[b*8 +: 8];
          mem[{mem_addr[31:2], 2'b00}] = v;
          wlog.push_back(mem_addr);
          pend--;
        end else begin
          reads++;
          if (pend != 0) drain_viol++;
          if (mem_be != 4'hF) rd_be_bad++;
        end
      end
    end
  end

  task automatic do_op(input logic we, input logic [31:0] a, input logic [3:0] be,
                       input logic [31:0] d, output logic [31:0] rd, output logic rv,
                       output int waited, output int nreads);
    int r0;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_be = be; cpu_wdata = d;
    r0 = reads;
    waited = 0;
    #1;
    while (cpu_stall) begin
      @(negedge clk);
      #1;
      waited++;
    end
    @(posedge clk);
    if (we) pend++;
    @(negedge clk);
    cpu_req = 1'b0;
    rd = cpu_rdata;
    rv = cpu_rvalid;
    nreads = reads - r0;
  endtask

  typedef struct packed {
    logic        we;
    logic [31:0] addr;
    logic [3:0]  be;
    logic [31:0] wd;
    logic [31:0] exp;
    logic        miss;
  } vec_t;

  // memory word default = address ^ 5A5A0000
  localparam vec_t VEC [13] = '{
    '{1'b0, 32'h0000_0100, 4'hF, 32'h0,         32'h5A5A_0100, 1'b1}, // R1 first load misses
    '{1'b0, 32'h0000_0100, 4'hF, 32'h0,         32'h5A5A_0100, 1'b0}, // R3 hit
    '{1'b0, 32'h0000_0104, 4'hF, 32'h0,         32'h5A5A_0104, 1'b1}, // R4 neighbour not filled
    '{1'b1, 32'h0000_0100, 4'h3, 32'h1122_3344, 32'h0,         1'b0}, // R6 masked hit update
    '{1'b0, 32'h0000_0100, 4'hF, 32'h0,         32'h5A5A_3344, 1'b0}, // R6 merged bytes
    '{1'b1, 32'h0000_0200, 4'hF, 32'hDEAD_BEEF, 32'h0,         1'b0}, // R5 store miss
    '{1'b0, 32'h0000_0200, 4'hF, 32'h0,         32'hDEAD_BEEF, 1'b1}, // R5 no allocate
    '{1'b0, 32'h0000_0900, 4'hF, 32'h0,         32'h5A5A_0900, 1'b1}, // R2 same line, new tag
    '{1'b0, 32'h0000_0104, 4'hF, 32'h0,         32'h5A5A_0104, 1'b1}, // R2 evicted
    '{1'b0, 32'h0000_0100, 4'hF, 32'h0,         32'h5A5A_3344, 1'b1}, // R2 evicted, R5 written through
    '{1'b1, 32'h0000_0108, 4'h8, 32'hAB00_0000, 32'h0,         1'b0}, // R5 byte store miss
    '{1'b0, 32'h0000_0108, 4'hF, 32'h0,         32'hAB5A_0108, 1'b1}, // R8 drained first
    '{1'b0, 32'h0000_0108, 4'hF, 32'h0,         32'hAB5A_0108, 1'b0}  // R3 hit after fill
  };

  initial begin
    #(8 * 50000);
    failures++;
    $display("FAIL watchdog R10 actual=hung expected=finished");
    report();
  end

  initial begin
    logic [31:0] rd;
    logic        rv;
    int          w, n, w0, w1, w2;
    mem_ack = 1'b0; mem_rdata = '0;
    cache_off = 1'b0; cpu_req = 1'b0; cpu_we = 1'b0;
    cpu_addr = '0; cpu_be = '0; cpu_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 mem_req in reset", 32'(mem_req), 32'd0);
    chk("R1 rvalid in reset", 32'(cpu_rvalid), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk("R1 stall idle", 32'(cpu_stall), 32'd0);
    chk("R1 rvalid idle", 32'(cpu_rvalid), 32'd0);
    chk("R1 mem_req idle", 32'(mem_req), 32'd0);

    for (int i = 0; i < 13; i++) begin
      do_op(VEC[i].we, VEC[i].addr, VEC[i].be, VEC[i].wd, rd, rv, w, n);
      if (!VEC[i].we) begin
        chk(VEC[i].miss ? "R4 miss data" : "R3 hit data", rd, VEC[i].exp);
        chk(VEC[i].miss ? "R4 one read" : "R3 no read", 32'(n), 32'(VEC[i].miss));
        chk("R3 rvalid", 32'(rv), 32'd1);
      end
    end

    // R9: disabled loads bypass, cached word survives
    mem[32'h0000_0108] = 32'h7777_7777;
    cache_off = 1'b1;
    do_op(1'b0, 32'h0000_0108, 4'hF, 32'h0, rd, rv, w, n);
    chk("R9 off load data", rd, 32'h7777_7777);
    chk("R9 off load read", 32'(n), 32'd1);
    cache_off = 1'b0;
    do_op(1'b0, 32'h0000_0108, 4'hF, 32'h0, rd, rv, w, n);
    chk("R9 kept word", rd, 32'hAB5A_0108);
    chk("R9 kept no read", 32'(n), 32'd0);

    // R7 / R8 with slow memory
    lat = 6;
    do_op(1'b1, 32'h0000_3000, 4'hF, 32'h0000_0001, rd, rv, w0, n);
    do_op(1'b1, 32'h0000_3004, 4'hF, 32'h0000_0002, rd, rv, w1, n);
    do_op(1'b1, 32'h0000_3008, 4'hF, 32'h0000_0003, rd, rv, w2, n);
    chk("R7 first store no wait", 32'(w0), 32'd0);
    chk("R7 second store no wait", 32'(w1), 32'd0);
    chk("R7 third store stalled", 32'(w2 > 0), 32'd1);
    do_op(1'b0, 32'h0000_4000, 4'hF, 32'h0, rd, rv, w, n);
    chk("R8 load data after drain", rd, 32'h5A5A_4000);
    chk("R8 no read before drain", 32'(drain_viol), 32'd0);
    chk("R5 order A", wlog[wlog.size()-3], 32'h0000_3000);
    chk("R5 order B", wlog[wlog.size()-2], 32'h0000_3004);
    chk("R5 order C", wlog[wlog.size()-1], 32'h0000_3008);
    chk("R5 memory C", mval(32'h0000_3008), 32'h0000_0003);
    chk("R4 read enables", 32'(rd_be_bad), 32'd0);
    chk("R10 request held", 32'(hold_viol), 32'd0);
    report();
  end
endmodule